// File: doc/BRIEF.md
# Pipelined Split Binary Counter

This block is an 8-bit free-running up-counter built from two 4-bit nibble counters. The increment logic of a plain 8-bit counter forms a chain from every bit up to the top bit. Here that chain is cut in two: the low nibble counts on its own, and the high nibble steps only when a registered carry allows it. This keeps every register-to-register path to roughly one nibble of logic, which lets the counter close timing at a higher clock rate.

Because the carry passes through a flip-flop, it is formed one count early. The low nibble flags the value 14. The registered flag is therefore high in exactly the cycle in which the low nibble rolls from 15 to 0, and the high nibble steps on that same edge. The sequence seen at the output is the same as that of an unpipelined 8-bit binary counter. A global count enable pauses the whole counter. A terminal-count flag marks the all-ones value.

Top module: `split_pipe_counter`

## Requirements
- R1: On each rising clock edge with rst_n high and cnt_en high, count becomes (count + 1) modulo 256, so the output follows a plain 8-bit binary up-count.
- R2: The low nibble count[3:0] steps by one on every enabled edge and rolls from 15 to 0.
- R3: The high nibble count[7:4] steps by one exactly on the enabled edge where count[3:0] rolls from 15 to 0, and holds its value on every other edge.
- R4: On an edge with rst_n high and cnt_en low, count keeps its value. This holds when the low nibble rests at 14 or 15, and the count continues correctly once enable returns.
- R5: On a rising edge with rst_n low (synchronous, active low), count becomes 0, whatever cnt_en is.
- R6: term_cnt is 1 exactly when count equals 255, and 0 otherwise.
- R7: An enabled edge while count is 255 gives count 0, with term_cnt then 0.
- R8: A reset that arrives while the low nibble is at 14 or 15 leaves no pending carry. After reset, the high nibble stays 0 until the 16th enabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count enable; low pauses the counter |
| count | output | 8 | Current count value, high nibble in bits 7:4 |
| term_cnt | output | 1 | High while count is 255 |

## Verification
A carry register that is out of step with the low nibble shows at the port as a high nibble that moves one enabled cycle early or late. It is therefore visible on the first roll of the low nibble after the fault, at most 16 enabled cycles later. A carry that survives reset, or one that is not held during a stall at 14 or 15, makes the high nibble step at a point where the binary sequence forbids it. The per-cycle comparison against a reference count sees this on the very edge it happens. The terminal flag is compared on every cycle, so a fault in it shows within one pass through 255.

// File: rtl/split_pipe_counter_pkg.sv
// Package: split_pipe_counter_pkg
// Shared sizes for the split pipelined counter. The nibble width is fixed
// by the architecture (two halves); derived widths live here so every module
// agrees on them.
package split_pipe_counter_pkg;
    localparam int unsigned NIBBLE_W = 4;
    localparam int unsigned TOTAL_W  = 2 * NIBBLE_W;

    typedef logic [NIBBLE_W-1:0] nibble_t;
    typedef logic [TOTAL_W-1:0]  count_t;
endpackage

// File: rtl/split_pipe_nibble.sv
// Module: split_pipe_nibble
// One sub-counter of width W with a step enable. It also reports, from its
// registered value alone, whether the value is one below all-ones
// (LOOKAHEAD=1) or at all-ones (LOOKAHEAD=0). The look-ahead form lets a
// carry flip-flop downstream line up with the roll-over edge.
// Assumes: synchronous active-low reset; step is already qualified by enable.
module split_pipe_nibble #(
    parameter int unsigned W         = 4,
    parameter bit          LOOKAHEAD = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] value,
    output logic         near_top
);
    localparam logic [W-1:0] TOP_VAL = {W{1'b1}};
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] val_q;

    // Hold or step the nibble value; cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (step) begin
            val_q <= val_q + ONE;
        end
    end

    // Pick the compare point for the carry flag from the parameter.
    generate
        if (LOOKAHEAD) begin : g_early
            assign near_top = (val_q == (TOP_VAL - ONE));
        end else begin : g_late
            assign near_top = (val_q == TOP_VAL);
        end
    endgenerate

    assign value = val_q;
endmodule

// File: rtl/split_pipe_carry_reg.sv
// Module: split_pipe_carry_reg
// The pipeline flip-flop between the two nibbles. It captures the early
// carry flag only on enabled cycles, so a stall freezes it together with
// the nibble it came from.
// Assumes: synchronous active-low reset clears it.
module split_pipe_carry_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic carry_in,
    output logic carry_q
);
    logic held_q;

    // Capture the early carry on enabled cycles; hold during stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else if (enable) begin
            held_q <= carry_in;
        end
    end

    assign carry_q = held_q;
endmodule

// File: rtl/split_pipe_counter.sv
// Module: split_pipe_counter
// Top of the pipelined split counter. The low nibble counts on every
// enabled edge. Its early carry (value 14) is registered, and the register
// output, qualified by the global enable, steps the high nibble on the edge
// where the low nibble rolls 15 -> 0. No path spans more than one nibble of
// increment logic plus one gate.
// Assumes: one clock, synchronous active-low reset, free-running up count.
module split_pipe_counter
    import split_pipe_counter_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_en,
    output logic [TOTAL_W-1:0] count,
    output logic               term_cnt
);
    localparam nibble_t NIB_MAX = {NIBBLE_W{1'b1}};

    nibble_t lo_val;
    nibble_t hi_val;
    logic    lo_early;
    logic    hi_early_unused;
    logic    hi_step_q;
    logic    hi_step;

    // Low half: steps whenever counting is enabled.
    split_pipe_nibble #(
        .W         (NIBBLE_W),
        .LOOKAHEAD (1'b1)
    ) lo_nib_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (cnt_en),
        .value    (lo_val),
        .near_top (lo_early)
    );

    // Pipeline flip-flop carrying the early carry to the high half.
    split_pipe_carry_reg carry_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (cnt_en),
        .carry_in (lo_early),
        .carry_q  (hi_step_q)
    );

    // The high half steps only when the registered carry and enable agree.
    assign hi_step = hi_step_q & cnt_en;

    // High half: no carry is taken out of it, so its flag is left unused.
    split_pipe_nibble #(
        .W         (NIBBLE_W),
        .LOOKAHEAD (1'b0)
    ) hi_nib_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (hi_step),
        .value    (hi_val),
        .near_top (hi_early_unused)
    );

    // Join the halves and flag the all-ones value.
    always_comb begin
        count    = {hi_val, lo_val};
        term_cnt = (hi_val == NIB_MAX) && (lo_val == NIB_MAX);
    end
endmodule

// File: rtl/split_pipe_counter_chk.sv
// Module: split_pipe_counter_chk
// Checker for the split counter, attached by bind. It relates the output
// sequence across edges and ties the internal carry register to the low
// nibble it must track.
// Assumes: reset is held low at time zero for at least one clock edge.
module split_pipe_counter_chk
    import split_pipe_counter_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cnt_en,
    input logic [TOTAL_W-1:0] count,
    input logic               term_cnt,
    input logic               hi_step_q
);
    localparam count_t CNT_ONE = {{(TOTAL_W-1){1'b0}}, 1'b1};

    AST_BINARY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> (count == $past(count) + CNT_ONE)); // R1

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(count)); // R4

    AST_HI_ONLY_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        (count[NIBBLE_W-1:0] != {NIBBLE_W{1'b1}}) |=>
            $stable(count[TOTAL_W-1:NIBBLE_W])); // R3

    AST_CARRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        hi_step_q |-> (count[NIBBLE_W-1:0] == {NIBBLE_W{1'b1}})); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (count == '0) && !hi_step_q); // R5

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (term_cnt && cnt_en) |=> (count == '0) && !term_cnt); // R7

    AST_TC_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        term_cnt |-> (count == {TOTAL_W{1'b1}})); // R6
endmodule

bind split_pipe_counter split_pipe_counter_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .count     (count),
    .term_cnt  (term_cnt),
    .hi_step_q (hi_step_q)
);

// File: tb/split_pipe_counter_tb.sv
`timescale 1ns/100ps
// Bench for split_pipe_counter: a behavioural integer reference counter
// stepped once per clock and compared with the outputs on every cycle.
module split_pipe_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic [7:0] count;
    logic       term_cnt;

    int ref_cnt = 0;
    int n_checks = 0;
    int n_errors = 0;
    int ena_since_rst = 0;
    bit done = 1'b0;

    split_pipe_counter dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .count    (count),
        .term_cnt (term_cnt)
    );

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Apply inputs at the falling edge, advance the reference at the rising
    // edge, then check at the next falling edge.
    task automatic cyc(input bit en, input bit rn, input string tag);
        cnt_en = en;
        rst_n  = rn;
        @(posedge clk);
        if (!rn) begin
            ref_cnt = 0;
            ena_since_rst = 0;
        end else if (en) begin
            ref_cnt = (ref_cnt + 1) % 256;
            ena_since_rst++;
        end
        @(negedge clk);
        check(tag, int'(count), ref_cnt);
        check("R2", int'(count[3:0]), ref_cnt % 16);
        check("R3", int'(count[7:4]), ref_cnt / 16);
        check("R6", int'(term_cnt), (ref_cnt == 255) ? 1 : 0);
    endtask

    initial begin
        @(negedge clk);
        cyc(1'b1, 1'b0, "R5");
        cyc(1'b0, 1'b0, "R5");
        // Count up to low nibble 14, then stall there.
        for (int i = 0; i < 14; i++) cyc(1'b1, 1'b1, "R1");
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, "R4");
        cyc(1'b1, 1'b1, "R4");
        // Now at 15: stall with the carry pending.
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, "R4");
        cyc(1'b1, 1'b1, "R3");
        check("R3", int'(count), 16);
        // Reach low nibble 14 again and reset there.
        for (int i = 0; i < 14; i++) cyc(1'b1, 1'b1, "R1");
        cyc(1'b1, 1'b0, "R8");
        // Reset at low nibble 15 with a pending carry.
        for (int i = 0; i < 15; i++) cyc(1'b1, 1'b1, "R8");
        cyc(1'b0, 1'b0, "R8");
        for (int i = 0; i < 15; i++) begin
            cyc(1'b1, 1'b1, "R8");
            check("R8", int'(count[7:4]), 0);
        end
        cyc(1'b1, 1'b1, "R8");
        check("R8", int'(count), 16);
        // Run to the top and through the wrap, with a stall at 255.
        while (ref_cnt != 255) cyc(1'b1, 1'b1, "R1");
        check("R6", int'(term_cnt), 1);
        cyc(1'b0, 1'b1, "R4");
        cyc(1'b1, 1'b1, "R7");
        check("R7", int'(count), 0);
        check("R7", int'(term_cnt), 0);
        // Random stalls and occasional mid-run resets.
        for (int i = 0; i < 3000; i++) begin
            bit en_r;
            bit rn_r;
            en_r = ($urandom_range(0, 3) != 0);
            rn_r = ($urandom_range(0, 499) != 0);
            cyc(en_r, rn_r, rn_r ? (en_r ? "R1" : "R4") : "R5");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule